// File: doc/BRIEF.md
# Global Counter with Compare Timer

This block is a memory-mapped system timer. It contains a 64-bit up-counter that advances by one on every clock while it is started. Software sees the counter as two 32-bit words. To get a consistent 64-bit value, software reads the upper word, then the lower word, then the upper word again, and retries if the two upper reads differ. A 64-bit comparator watches the counter and latches an interrupt status flag on an exact match. The interrupt line is that flag gated by an enable bit. When auto-increment is on, each match adds a programmed increment to the comparator, so the events repeat with a fixed period.

Writes to the counter words, the comparator words, the increment and the control word do not land at once. They travel through a commit pipeline of `COMMIT_LAT` stages. When a write lands, it raises a sticky write-status bit. Software polls that bit to learn that the value is in place, then clears it by writing a one to it. Writes to the interrupt enable take effect on the edge that samples them, and so do the write-one-to-clear writes to the status registers.

Reads are combinational from `bus_addr` and have no side effects. The bus presents at most one write per cycle.

Top module: `gtimer`

## Requirements
- R1: After synchronous reset every readable register reads zero and `irq_o` is low.
- R2: While control bit 8 (run) is set, the counter rises by exactly one per clock. While it is clear, the counter holds its value.
- R3: A write to 0x100 (counter low word) or 0x104 (counter high word) replaces only that half. The new value lands on the `COMMIT_LAT`-th rising edge after the edge that samples the write, and in that cycle it takes priority over counting. A carry out of the low word reaches the high word while the counter runs.
- R4: A write to 0x100 sets bit 0 of 0x110 and a write to 0x104 sets bit 1 of 0x110. Writes to 0x200, 0x204, 0x208 and 0x240 set bits 0, 1, 2 and 16 of 0x24C respectively. Each bit is set on the same edge the written value lands and reads 0 before that edge.
- R5: Writing a 1 to a write-status bit in 0x110 or 0x24C clears it on the sampling edge. Bits written with 0 keep their value.
- R6: A match needs all of three things: counter equal to the comparator (0x200 low, 0x204 high) on all 64 bits, control bit 0 (compare enable) set, and the run bit set. A match sets bit 0 of 0x244 on the next edge. With compare enable clear, no match occurs.
- R7: Bit 0 of 0x244 stays set until a write to 0x244 with bit 0 equal to 1. A write with bit 0 equal to 0 leaves it set.
- R8: `irq_o` is high exactly when bit 0 of 0x244 and bit 0 of 0x248 (interrupt enable, written directly) are both set.
- R9: With control bit 1 (auto-increment) set, each match adds the 64-bit increment in 0x208 to the comparator, carrying into the high word. Successive matches are therefore spaced by the increment value in clocks.
- R10: With auto-increment clear, a match leaves the comparator unchanged, so no further match occurs until the counter comes round again.
- R11: Register reads return the committed values. Of the control word, only bits 8, 1 and 0 read back, and the interrupt enable reads only bit 0. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 12 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Compare interrupt request |

## Verification
The bench counts the edges between a comparator write and its write-status bit. A design that commits one stage early or late shows the bit at the wrong sample. It then steps the counter across the 32-bit boundary, both as a counter and as an auto-incremented comparator. A lost carry leaves the high word stuck at its old value.

It measures the spacing between repeated auto-increment matches. A design that reloaded the comparator from the wrong value would fire at a wrong period, or only once. It also confirms that a one-shot match neither re-arms nor clears itself, and that the compare enable really gates matching. Writes of zero to the clear registers must leave the sticky bits untouched. A design that treats any write as a clear fails this check.

// File: rtl/gtimer_pkg.sv
`timescale 1ns/1ps
package gtimer_pkg;

    localparam int unsigned ADDR_W = 12;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned CNT_W  = 2 * WORD_W;

    // register map
    localparam logic [ADDR_W-1:0] A_CNT_LO  = 12'h100;
    localparam logic [ADDR_W-1:0] A_CNT_HI  = 12'h104;
    localparam logic [ADDR_W-1:0] A_CNT_WS  = 12'h110;
    localparam logic [ADDR_W-1:0] A_CMP_LO  = 12'h200;
    localparam logic [ADDR_W-1:0] A_CMP_HI  = 12'h204;
    localparam logic [ADDR_W-1:0] A_INCR    = 12'h208;
    localparam logic [ADDR_W-1:0] A_CTRL    = 12'h240;
    localparam logic [ADDR_W-1:0] A_INT_ST  = 12'h244;
    localparam logic [ADDR_W-1:0] A_INT_EN  = 12'h248;
    localparam logic [ADDR_W-1:0] A_REG_WS  = 12'h24C;

    // control word bit positions
    localparam int unsigned CTRL_RUN_BIT  = 8;
    localparam int unsigned CTRL_AUTO_BIT = 1;
    localparam int unsigned CTRL_CEN_BIT  = 0;

    // bit position of the control write-status flag in the register status word
    localparam int unsigned WS_CTRL_BIT = 16;

    // registers reached through the commit pipeline
    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_CNT_LO,
        TGT_CNT_HI,
        TGT_CMP_LO,
        TGT_CMP_HI,
        TGT_INCR,
        TGT_CTRL
    } tgt_e;

    typedef struct packed {
        logic              vld;
        tgt_e              tgt;
        logic [WORD_W-1:0] data;
    } commit_t;

    typedef struct packed {
        logic run;
        logic auto_inc;
        logic cmp_en;
    } ctrl_t;

    function automatic tgt_e decode_tgt(input logic [ADDR_W-1:0] a);
        tgt_e t;
        case (a)
            A_CNT_LO: t = TGT_CNT_LO;
            A_CNT_HI: t = TGT_CNT_HI;
            A_CMP_LO: t = TGT_CMP_LO;
            A_CMP_HI: t = TGT_CMP_HI;
            A_INCR:   t = TGT_INCR;
            A_CTRL:   t = TGT_CTRL;
            default:  t = TGT_NONE;
        endcase
        return t;
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CTRL_RUN_BIT]  = c.run;
        w[CTRL_AUTO_BIT] = c.auto_inc;
        w[CTRL_CEN_BIT]  = c.cmp_en;
        return w;
    endfunction

    // pack {ctrl, incr, cmp_hi, cmp_lo} status flags into the register status word
    function automatic logic [WORD_W-1:0] reg_ws_to_word(input logic [3:0] q);
        logic [WORD_W-1:0] w;
        w = '0;
        w[2:0]        = q[2:0];
        w[WS_CTRL_BIT] = q[3];
        return w;
    endfunction

endpackage

// File: rtl/gtimer_commit_pipe.sv
`timescale 1ns/1ps
module gtimer_commit_pipe
    import gtimer_pkg::*;
#(
    parameter int unsigned LAT = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  commit_t in_c,
    output commit_t out_c
);
    commit_t stg [LAT];

    for (genvar g = 0; g < LAT; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= in_c;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    // the last stage is applied by its consumers on the following edge
    assign out_c = stg[LAT-1];

endmodule

// File: rtl/gtimer_counter.sv
`timescale 1ns/1ps
module gtimer_counter
    import gtimer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  commit_t          cmt,
    output logic [CNT_W-1:0] cnt
);
    logic wr_lo, wr_hi;
    assign wr_lo = cmt.vld && (cmt.tgt == TGT_CNT_LO);
    assign wr_hi = cmt.vld && (cmt.tgt == TGT_CNT_HI);

    always_ff @(posedge clk) begin
        if (rst)        cnt <= '0;
        else if (wr_lo) cnt[WORD_W-1:0] <= cmt.data;
        else if (wr_hi) cnt[CNT_W-1:WORD_W] <= cmt.data;
        else if (run)   cnt <= cnt + 1'b1;
    end

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        run && !wr_lo && !wr_hi |=> cnt == $past(cnt) + 1'b1);

    assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !run && !wr_lo && !wr_hi |=> $stable(cnt));

    assert_half_write_R3: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> cnt[CNT_W-1:WORD_W] == $past(cnt[CNT_W-1:WORD_W]));

endmodule

// File: rtl/gtimer_compare.sv
`timescale 1ns/1ps
module gtimer_compare
    import gtimer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] cnt,
    input  commit_t          cmt,
    output logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] incr,
    output logic             match
);
    logic wr_lo, wr_hi, wr_inc;
    assign wr_lo  = cmt.vld && (cmt.tgt == TGT_CMP_LO);
    assign wr_hi  = cmt.vld && (cmt.tgt == TGT_CMP_HI);
    assign wr_inc = cmt.vld && (cmt.tgt == TGT_INCR);

    assign match = ctrl.cmp_en && ctrl.run && (cnt == cmp);

    always_ff @(posedge clk) begin
        if (rst)                          cmp <= '0;
        else if (wr_lo)                   cmp[WORD_W-1:0] <= cmt.data;
        else if (wr_hi)                   cmp[CNT_W-1:WORD_W] <= cmt.data;
        else if (match && ctrl.auto_inc)  cmp <= cmp + incr;
    end

    // the increment register holds a 32-bit value zero-extended to the counter width
    always_ff @(posedge clk) begin
        if (rst)         incr <= '0;
        else if (wr_inc) incr <= {{(CNT_W-WORD_W){1'b0}}, cmt.data};
    end

    assert_auto_reload_R9: assert property (@(posedge clk) disable iff (rst)
        match && ctrl.auto_inc && !wr_lo && !wr_hi |=> cmp == $past(cmp) + $past(incr));

    assert_oneshot_keep_R10: assert property (@(posedge clk) disable iff (rst)
        match && !ctrl.auto_inc && !wr_lo && !wr_hi |=> $stable(cmp));

endmodule

// File: rtl/gtimer_sticky.sv
`timescale 1ns/1ps
module gtimer_sticky #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)           q_o[g] <= 1'b0;
            else if (set_i[g]) q_o[g] <= 1'b1;
            else if (clr_i[g]) q_o[g] <= 1'b0;
        end

        assert_ws_set_R4: assert property (@(posedge clk) disable iff (rst)
            set_i[g] |=> q_o[g]);

        assert_ws_keep_R5: assert property (@(posedge clk) disable iff (rst)
            q_o[g] && !clr_i[g] |=> q_o[g]);

        assert_ws_clear_R5: assert property (@(posedge clk) disable iff (rst)
            clr_i[g] && !set_i[g] |=> !q_o[g]);
    end

endmodule

// File: rtl/gtimer.sv
`timescale 1ns/1ps
module gtimer
    import gtimer_pkg::*;
#(
    parameter int unsigned COMMIT_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq_o
);
    localparam int unsigned CNT_WS_N = 2;
    localparam int unsigned REG_WS_N = 4;

    commit_t          cmt_in, cmt;
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cnt, cmp, incr;
    logic             match;
    logic             int_st_q, int_en_q;
    logic             st_clr;
    logic [CNT_WS_N-1:0] cnt_ws_set, cnt_ws_clr, cnt_ws_q;
    logic [REG_WS_N-1:0] reg_ws_set, reg_ws_clr, reg_ws_q;

    // writes to pipelined registers enter the commit pipe
    always_comb begin
        cmt_in      = '0;
        cmt_in.tgt  = decode_tgt(bus_addr);
        cmt_in.vld  = bus_wr && (cmt_in.tgt != TGT_NONE);
        cmt_in.data = bus_wdata;
    end

    gtimer_commit_pipe #(.LAT(COMMIT_LAT)) u_pipe (
        .clk   (clk),
        .rst   (rst),
        .in_c  (cmt_in),
        .out_c (cmt)
    );

    // control word, committed
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (cmt.vld && cmt.tgt == TGT_CTRL) begin
            ctrl_q.run      <= cmt.data[CTRL_RUN_BIT];
            ctrl_q.auto_inc <= cmt.data[CTRL_AUTO_BIT];
            ctrl_q.cmp_en   <= cmt.data[CTRL_CEN_BIT];
        end
    end

    gtimer_counter u_cnt (
        .clk (clk),
        .rst (rst),
        .run (ctrl_q.run),
        .cmt (cmt),
        .cnt (cnt)
    );

    gtimer_compare u_cmp (
        .clk   (clk),
        .rst   (rst),
        .ctrl  (ctrl_q),
        .cnt   (cnt),
        .cmt   (cmt),
        .cmp   (cmp),
        .incr  (incr),
        .match (match)
    );

    // write-status flags
    always_comb begin
        cnt_ws_set = {cmt.vld && cmt.tgt == TGT_CNT_HI,
                      cmt.vld && cmt.tgt == TGT_CNT_LO};
        reg_ws_set = {cmt.vld && cmt.tgt == TGT_CTRL,
                      cmt.vld && cmt.tgt == TGT_INCR,
                      cmt.vld && cmt.tgt == TGT_CMP_HI,
                      cmt.vld && cmt.tgt == TGT_CMP_LO};
        cnt_ws_clr = (bus_wr && bus_addr == A_CNT_WS) ? bus_wdata[CNT_WS_N-1:0] : '0;
        reg_ws_clr = (bus_wr && bus_addr == A_REG_WS)
                   ? {bus_wdata[WS_CTRL_BIT], bus_wdata[2:0]} : '0;
    end

    gtimer_sticky #(.N(CNT_WS_N)) u_cnt_ws (
        .clk   (clk),
        .rst   (rst),
        .set_i (cnt_ws_set),
        .clr_i (cnt_ws_clr),
        .q_o   (cnt_ws_q)
    );

    gtimer_sticky #(.N(REG_WS_N)) u_reg_ws (
        .clk   (clk),
        .rst   (rst),
        .set_i (reg_ws_set),
        .clr_i (reg_ws_clr),
        .q_o   (reg_ws_q)
    );

    // interrupt status and enable, direct writes
    assign st_clr = bus_wr && (bus_addr == A_INT_ST) && bus_wdata[0];

    always_ff @(posedge clk) begin
        if (rst)         int_st_q <= 1'b0;
        else if (match)  int_st_q <= 1'b1;
        else if (st_clr) int_st_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)                                  int_en_q <= 1'b0;
        else if (bus_wr && bus_addr == A_INT_EN)  int_en_q <= bus_wdata[0];
    end

    assign irq_o = int_st_q & int_en_q;

    // read mux
    always_comb begin
        case (bus_addr)
            A_CNT_LO: bus_rdata = cnt[WORD_W-1:0];
            A_CNT_HI: bus_rdata = cnt[CNT_W-1:WORD_W];
            A_CNT_WS: bus_rdata = {{(WORD_W-CNT_WS_N){1'b0}}, cnt_ws_q};
            A_CMP_LO: bus_rdata = cmp[WORD_W-1:0];
            A_CMP_HI: bus_rdata = cmp[CNT_W-1:WORD_W];
            A_INCR:   bus_rdata = incr[WORD_W-1:0];
            A_CTRL:   bus_rdata = ctrl_to_word(ctrl_q);
            A_INT_ST: bus_rdata = {{(WORD_W-1){1'b0}}, int_st_q};
            A_INT_EN: bus_rdata = {{(WORD_W-1){1'b0}}, int_en_q};
            A_REG_WS: bus_rdata = reg_ws_to_word(reg_ws_q);
            default:  bus_rdata = '0;
        endcase
    end

    assert_match_sets_R6: assert property (@(posedge clk) disable iff (rst)
        match |=> int_st_q);

    assert_status_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        int_st_q && !st_clr |=> int_st_q);

    assert_irq_follows_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(int_st_q) && int_en_q |-> irq_o);

    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (rst)
        !int_en_q |-> !irq_o);

    assert_no_match_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.cmp_en |-> !match);

endmodule

// File: tb/gtimer_tb.sv
`timescale 1ns/1ps
module gtimer_tb;

    localparam int LAT = 2;
    localparam int NV  = 10;

    // stimulus table: address, written data, expected read-back (R3, R11)
    localparam logic [11:0] T_ADDR [NV] = '{
        12'h200, 12'h204, 12'h208, 12'h100, 12'h104,
        12'h248, 12'h240, 12'h240, 12'h300, 12'h248 };
    localparam logic [31:0] T_WDATA [NV] = '{
        32'h1234_5678, 32'hCAFE_0001, 32'h0000_0040, 32'hDEAD_BEEF, 32'h0000_00A5,
        32'hFFFF_FFFF, 32'hFFFF_FEFC, 32'h0000_0003, 32'hFFFF_FFFF, 32'h0000_0000 };
    localparam logic [31:0] T_EXP [NV] = '{
        32'h1234_5678, 32'hCAFE_0001, 32'h0000_0040, 32'hDEAD_BEEF, 32'h0000_00A5,
        32'h0000_0001, 32'h0000_0000, 32'h0000_0003, 32'h0000_0000, 32'h0000_0000 };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    gtimer #(.COMMIT_LAT(LAT)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // all tasks are entered at a falling edge and return at a falling edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr_commit(input logic [11:0] a, input logic [31:0] d);
        wr(a, d);
        repeat (LAT) @(negedge clk);
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v, a, b, h1, h2;
        int rise [4];
        int nr;

        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        rd(12'h100, v); chk("R1 cnt_lo", v, 0);
        rd(12'h240, v); chk("R1 ctrl", v, 0);
        rd(12'h24C, v); chk("R1 reg_ws", v, 0);
        rd(12'h200, v); chk("R1 cmp_lo", v, 0);
        chk("R1 irq", irq_o, 0);

        // table walk: write, wait for commit, read back (R11)
        for (int i = 0; i < NV; i++) begin
            wr_commit(T_ADDR[i], T_WDATA[i]);
            rd(T_ADDR[i], v);
            chk("R11 readback", v, T_EXP[i]);
        end
        wr_commit(12'h240, 32'h0);

        // R5 clears, R4 latency
        wr(12'h24C, 32'hFFFF_FFFF);
        wr(12'h110, 32'h3);
        rd(12'h24C, v); chk("R5 reg_ws cleared", v, 0);
        rd(12'h110, v); chk("R5 cnt_ws cleared", v, 0);
        wr(12'h200, 32'h77);
        idle(LAT - 1);
        rd(12'h24C, v); chk("R4 before commit", v, 0);
        idle(1);
        rd(12'h24C, v); chk("R4 at commit", v, 32'h1);
        wr_commit(12'h240, 32'h0);
        rd(12'h24C, v); chk("R4 ctrl bit16", v, 32'h1_0001);
        wr(12'h24C, 32'h0);
        rd(12'h24C, v); chk("R5 zero write keeps", v, 32'h1_0001);
        wr(12'h24C, 32'h1);
        rd(12'h24C, v); chk("R5 w1c bit0", v, 32'h1_0000);
        wr_commit(12'h104, 32'h0);
        rd(12'h110, v); chk("R4 cnt_hi status", v, 32'h2);

        // R2 counting and holding
        wr_commit(12'h100, 32'h0);
        wr_commit(12'h240, 32'h100);
        rd(12'h100, a); idle(10); rd(12'h100, b);
        chk("R2 counts", b - a, 10);
        wr_commit(12'h240, 32'h0);
        rd(12'h100, a); idle(5); rd(12'h100, b);
        chk("R2 holds", b, a);

        // R3 carry into high word, three-read method
        wr_commit(12'h100, 32'hFFFF_FFF0);
        wr_commit(12'h104, 32'h5);
        wr_commit(12'h240, 32'h100);
        idle(30);
        rd(12'h104, h1); rd(12'h100, v); rd(12'h104, h2);
        chk("R3 hi stable", h2, h1);
        chk("R3 carry hi", h1, 6);
        chk("R3 carry lo small", v < 32'h20, 1);
        // write low word while running: lands exactly, beats the increment
        wr_commit(12'h100, 32'h1000);
        rd(12'h100, v); chk("R3 write while running", v, 32'h1000);
        rd(12'h104, v); chk("R3 hi untouched", v, 6);

        // R6 comparator disabled: no match
        wr_commit(12'h240, 32'h0);
        wr_commit(12'h104, 32'h0);
        wr_commit(12'h100, 32'h0);
        wr_commit(12'h200, 32'd10);
        wr_commit(12'h204, 32'h0);
        wr(12'h248, 32'h1);
        wr_commit(12'h240, 32'h100);
        idle(40);
        rd(12'h244, v); chk("R6 disabled no match", v, 0);
        chk("R8 irq low no status", irq_o, 0);

        // one-shot match R6 R7 R8 R10
        wr_commit(12'h240, 32'h0);
        wr_commit(12'h100, 32'h0);
        wr_commit(12'h200, 32'd30);
        wr_commit(12'h208, 32'h0);
        wr_commit(12'h240, 32'h101);
        idle(60);
        rd(12'h244, v); chk("R6 match sets status", v, 1);
        chk("R8 irq high", irq_o, 1);
        rd(12'h200, v); chk("R10 cmp unchanged", v, 30);
        idle(20);
        rd(12'h244, v); chk("R7 status sticky", v, 1);
        wr(12'h248, 32'h0);
        chk("R8 irq masked", irq_o, 0);
        wr(12'h248, 32'h1);
        chk("R8 irq unmasked", irq_o, 1);
        wr(12'h244, 32'h0);
        rd(12'h244, v); chk("R7 zero write keeps", v, 1);
        wr(12'h244, 32'h1);
        rd(12'h244, v); chk("R7 w1c clears", v, 0);
        chk("R8 irq after clear", irq_o, 0);
        idle(20);
        rd(12'h244, v); chk("R10 no repeat", v, 0);

        // R9 periodic matches
        wr_commit(12'h240, 32'h0);
        wr_commit(12'h100, 32'h0);
        wr_commit(12'h200, 32'd40);
        wr_commit(12'h208, 32'd16);
        wr(12'h244, 32'h1);
        wr_commit(12'h240, 32'h103);
        rd(12'h240, v); chk("R11 ctrl readback", v, 32'h103);
        nr = 0;
        for (int k = 0; k < 300 && nr < 4; k++) begin
            rd(12'h244, v);
            if (v[0]) begin
                rise[nr] = cyc;
                nr++;
                wr(12'h244, 32'h1);
            end else begin
                idle(1);
            end
        end
        chk("R9 four matches", nr, 4);
        chk("R9 period a", rise[2] - rise[1], 16);
        chk("R9 period b", rise[3] - rise[2], 16);

        // R9 comparator carry into high word
        wr_commit(12'h240, 32'h0);
        wr_commit(12'h100, 32'hFFFF_FFF0);
        wr_commit(12'h104, 32'h0);
        wr_commit(12'h200, 32'hFFFF_FFF8);
        wr_commit(12'h204, 32'h0);
        wr_commit(12'h240, 32'h103);
        idle(12);
        rd(12'h204, v); chk("R9 cmp carry hi", v, 1);
        rd(12'h200, v); chk("R9 cmp carry lo", v, 32'h8);

        summary();
        $finish;
    end

endmodule